// File: doc/BRIEF.md
# Double SHA-256 Nonce Search Controller

This block searches the 32-bit nonce space of an 80-byte block header for a value whose double SHA-256 result meets a 256-bit target. The compressed state of the header's first 64 bytes is supplied once as a midstate, because that part of the header never changes while the nonce varies. The last twelve bytes before the nonce are supplied as three words, already in hashing word order. Each candidate nonce therefore costs two chunk compressions, both with fixed padding, instead of three.

For each nonce the controller builds the second chunk of the first pass from the header tail and the byte-swapped nonce, then compresses it starting from the midstate. It wraps the resulting 256-bit digest into a single padded chunk and compresses that from the standard SHA-256 initial values. The final digest is byte-reversed and compared as an unsigned number against the target. A single sequential engine does all the compression work, one round per clock. The engine is shared between the two passes.

A search is started by a one-cycle start pulse. The controller either reports the first matching nonce or reports that the nonce space was exhausted. The result is held until the next start.

Top module: `nonce_search`

## Requirements
- R1: After reset busy_o, found_o and exhausted_o are low, and nonce_o and hash_o are zero.
- R2: Pass one compresses, from the midstate (midstate_i[255:224] is the first state word), a chunk whose words 0..2 are tail_i (tail_i[95:64] first), word 3 is the nonce with its four bytes reversed, word 4 is 0x80000000, words 5..14 are zero and word 15 is 640.
- R3: Pass two compresses, from the standard SHA-256 initial values, a chunk whose words 0..7 are the pass-one digest (first state word first), word 8 is 0x80000000, words 9..14 are zero and word 15 is 256.
- R4: The pass-two digest with its 32 bytes reversed (last digest byte becomes the most significant) is a hit when it is less than or equal to target_i as an unsigned number. On a hit found_o rises, nonce_o holds the nonce and hash_o holds the reversed digest.
- R5: Nonces are tested in ascending order starting at nonce_start_i, and the first hit ends the search.
- R6: If nonce 0xFFFFFFFF is tested without a hit, exhausted_o rises, found_o stays low, and nonce_o reads 0xFFFFFFFF.
- R7: found_o, exhausted_o, nonce_o and hash_o hold until the next start_i. A start_i pulse while busy_o is high is ignored, and at most one of busy_o, found_o and exhausted_o is high.
- R8: found_o or exhausted_o becomes visible exactly 132 clock cycles per tested nonce after the clock edge that samples start_i. This is 66 cycles per compression, 64 of them rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that latches the inputs and starts a search |
| midstate_i | input | 256 | Compressed state after the first header chunk |
| tail_i | input | 96 | Header words preceding the nonce in the second chunk |
| nonce_start_i | input | 32 | First nonce to test |
| target_i | input | 256 | Largest acceptable byte-reversed result |
| busy_o | output | 1 | Search in progress |
| found_o | output | 1 | Search ended on a hit |
| exhausted_o | output | 1 | Search ended after nonce 0xFFFFFFFF without a hit |
| nonce_o | output | 32 | Nonce under test, or the reported nonce once stopped |
| hash_o | output | 256 | Byte-reversed final digest of the last completed nonce |

## Verification
The assertions take for granted that start_i is a single-cycle pulse and that the core is only launched by the controller while idle. They also assume target_i is meaningful only at the sampling edge, because all search inputs are latched there. The stimulus raises start_i for exactly one cycle and changes the search inputs only around that edge or while the search runs. The bench also deliberately pulses start_i mid-search to confirm that it is ignored. Targets are derived from digests computed in the bench for a short window of nonces, so each search ends after a few candidates. One search is placed just below the top of the nonce space with a target slightly under both digests, to force exhaustion.

// File: rtl/sha_pkg.sv
package sha_pkg;
  localparam int WORD_W  = 32;
  localparam int STATE_W = 8 * WORD_W;
  localparam int BLOCK_W = 16 * WORD_W;
  localparam int ROUNDS  = 64;
  localparam int CNT_W   = $clog2(ROUNDS);

  localparam logic [STATE_W-1:0] SHA_IV = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [ROUNDS*WORD_W-1:0] K_TAB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  typedef enum logic [2:0] {
    S_IDLE, S_GO1, S_RUN1, S_GO2, S_RUN2, S_FOUND, S_EXH
  } srch_state_e;

  typedef enum logic [1:0] {C_IDLE, C_RUN, C_FIN} core_state_e;

  function automatic logic [WORD_W-1:0] k_of(input logic [CNT_W-1:0] idx);
    return K_TAB[(ROUNDS-1-int'(idx))*WORD_W +: WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] big_s0(input logic [WORD_W-1:0] x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic logic [WORD_W-1:0] big_s1(input logic [WORD_W-1:0] x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic logic [WORD_W-1:0] sml_s0(input logic [WORD_W-1:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [WORD_W-1:0] sml_s1(input logic [WORD_W-1:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [STATE_W-1:0] brev_state(input logic [STATE_W-1:0] x);
    logic [STATE_W-1:0] r;
    for (int i = 0; i < STATE_W / 8; i++) r[i*8 +: 8] = x[STATE_W-8-i*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/sha_sched.sv
module sha_sched
  import sha_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    adv_i,
  input  logic [DEPTH*WORD_W-1:0] block_i,
  output logic [WORD_W-1:0]       w_o
);
  logic [WORD_W-1:0] win_q [DEPTH];
  logic [WORD_W-1:0] w_new;

  // window slot j holds W[t+j]; next word is W[t+16]
  assign w_new = sml_s1(win_q[DEPTH-2]) + win_q[DEPTH-7] + sml_s0(win_q[1]) + win_q[0];
  assign w_o   = win_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) win_q[j] <= '0;
    end else if (load_i) begin
      for (int j = 0; j < DEPTH; j++) win_q[j] <= block_i[(DEPTH-1-j)*WORD_W +: WORD_W];
    end else if (adv_i) begin
      for (int j = 0; j < DEPTH-1; j++) win_q[j] <= win_q[j+1];
      win_q[DEPTH-1] <= w_new;
    end
  end

  // R8
  no_load_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && adv_i));
endmodule

// File: rtl/sha_core.sv
module sha_core
  import sha_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [STATE_W-1:0] init_i,
  input  logic [BLOCK_W-1:0] block_i,
  output logic               done_o,
  output logic [STATE_W-1:0] digest_o
);
  core_state_e       st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [STATE_W-1:0] init_q;
  logic [WORD_W-1:0] v_q [8];
  logic [WORD_W-1:0] w_cur, t1, t2;
  logic              run, load;

  assign run  = (st_q == C_RUN);
  assign load = go_i && (st_q == C_IDLE);

  sha_sched #(.DEPTH(16)) u_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (run),
    .block_i(block_i),
    .w_o    (w_cur)
  );

  assign t1 = v_q[7] + big_s1(v_q[4]) + ((v_q[4] & v_q[5]) ^ (~v_q[4] & v_q[6]))
            + k_of(cnt_q) + w_cur;
  assign t2 = big_s0(v_q[0]) + ((v_q[0] & v_q[1]) ^ (v_q[0] & v_q[2]) ^ (v_q[1] & v_q[2]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= C_IDLE;
      cnt_q  <= '0;
      init_q <= '0;
      for (int j = 0; j < 8; j++) v_q[j] <= '0;
    end else begin
      case (st_q)
        C_IDLE: if (go_i) begin
          st_q   <= C_RUN;
          cnt_q  <= '0;
          init_q <= init_i;
          for (int j = 0; j < 8; j++) v_q[j] <= init_i[(7-j)*WORD_W +: WORD_W];
        end
        C_RUN: begin
          v_q[0] <= t1 + t2;
          v_q[1] <= v_q[0];
          v_q[2] <= v_q[1];
          v_q[3] <= v_q[2];
          v_q[4] <= v_q[3] + t1;
          v_q[5] <= v_q[4];
          v_q[6] <= v_q[5];
          v_q[7] <= v_q[6];
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ROUNDS-1)) st_q <= C_FIN;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign done_o = (st_q == C_FIN);

  for (genvar g = 0; g < 8; g++) begin : g_fold
    assign digest_o[(7-g)*WORD_W +: WORD_W] = init_q[(7-g)*WORD_W +: WORD_W] + v_q[g];
  end

  // R8
  round_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt_q != CNT_W'(ROUNDS-1)) |=> (run && cnt_q == $past(cnt_q) + 1'b1));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  go_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> st_q == C_IDLE);
endmodule

// File: rtl/nonce_search.sv
module nonce_search
  import sha_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [STATE_W-1:0] midstate_i,
  input  logic [3*WORD_W-1:0] tail_i,
  input  logic [WORD_W-1:0]  nonce_start_i,
  input  logic [STATE_W-1:0] target_i,
  output logic               busy_o,
  output logic               found_o,
  output logic               exhausted_o,
  output logic [WORD_W-1:0]  nonce_o,
  output logic [STATE_W-1:0] hash_o
);
  localparam logic [WORD_W-1:0] PAD_ONE  = 32'h8000_0000;
  localparam logic [WORD_W-1:0] LEN_HDR  = WORD_W'(640);
  localparam logic [WORD_W-1:0] LEN_DIG  = WORD_W'(STATE_W);
  localparam logic [WORD_W-1:0] NONCE_TOP = '1;

  srch_state_e        st_q;
  logic [WORD_W-1:0]  nonce_q;
  logic [STATE_W-1:0] mid_q, target_q, dig1_q, hash_q;
  logic [3*WORD_W-1:0] tail_q;

  logic               core_go, core_done, idle, hit;
  logic [STATE_W-1:0] core_init, core_dig, hash_le;
  logic [BLOCK_W-1:0] core_blk, blk1, blk2;

  assign idle = (st_q == S_IDLE) || (st_q == S_FOUND) || (st_q == S_EXH);

  assign blk1 = {tail_q, bswap32(nonce_q), PAD_ONE, {10*WORD_W{1'b0}}, LEN_HDR};
  assign blk2 = {dig1_q, PAD_ONE, {6*WORD_W{1'b0}}, LEN_DIG};

  assign core_go   = (st_q == S_GO1) || (st_q == S_GO2);
  assign core_init = (st_q == S_GO2) ? SHA_IV : mid_q;
  assign core_blk  = (st_q == S_GO2) ? blk2 : blk1;

  sha_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (core_go),
    .init_i  (core_init),
    .block_i (core_blk),
    .done_o  (core_done),
    .digest_o(core_dig)
  );

  assign hash_le = brev_state(core_dig);
  assign hit     = (hash_le <= target_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      nonce_q  <= '0;
      mid_q    <= '0;
      tail_q   <= '0;
      target_q <= '0;
      dig1_q   <= '0;
      hash_q   <= '0;
    end else begin
      case (st_q)
        S_GO1:  st_q <= S_RUN1;
        S_GO2:  st_q <= S_RUN2;
        S_RUN1: if (core_done) begin
          dig1_q <= core_dig;
          st_q   <= S_GO2;
        end
        S_RUN2: if (core_done) begin
          hash_q <= hash_le;
          if (hit)                     st_q <= S_FOUND;
          else if (nonce_q == NONCE_TOP) st_q <= S_EXH;
          else begin
            nonce_q <= nonce_q + 1'b1;
            st_q    <= S_GO1;
          end
        end
        default: if (start_i) begin
          nonce_q  <= nonce_start_i;
          mid_q    <= midstate_i;
          tail_q   <= tail_i;
          target_q <= target_i;
          st_q     <= S_GO1;
        end
      endcase
    end
  end

  assign busy_o      = !idle;
  assign found_o     = (st_q == S_FOUND);
  assign exhausted_o = (st_q == S_EXH);
  assign nonce_o     = nonce_q;
  assign hash_o      = hash_q;

  // R7
  flags_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, found_o, exhausted_o}));
  // R7
  found_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && !start_i) |=> (found_o && $stable(nonce_o) && $stable(hash_o)));
  // R4
  found_meets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (hash_o <= target_q));
  // R6
  exh_nonce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exhausted_o |-> (nonce_o == NONCE_TOP));
  // R5
  nonce_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_GO1 && $past(st_q) == S_RUN2) |-> (nonce_o == $past(nonce_o) + 1'b1));
  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && st_q != S_RUN2) |=> $stable(nonce_o));
endmodule

// File: tb/sim_nonce_search.sv
module sim_nonce_search;
  import sha_pkg::SHA_IV;
  import sha_pkg::K_TAB;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] mid = '0;
  logic [95:0]  tail = '0;
  logic [31:0]  nstart = '0;
  logic [255:0] tgt = '0;
  logic         busy, found, exh;
  logic [31:0]  nonce;
  logic [255:0] hash;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  nonce_search u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .midstate_i(mid), .tail_i(tail),
    .nonce_start_i(nstart), .target_i(tgt), .busy_o(busy), .found_o(found),
    .exhausted_o(exh), .nonce_o(nonce), .hash_o(hash));

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] compress(input logic [255:0] st, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, h, x1, x2;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
    {a, b, c, d, e, f, g, h} = st;
    for (int t = 0; t < 64; t++) begin
      x1 = h + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g))
         + K_TAB[2047-32*t -: 32] + w[t];
      x2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + x1; d = c; c = b; b = a; a = x1 + x2;
    end
    return {st[255:224] + a, st[223:192] + b, st[191:160] + c, st[159:128] + d,
            st[127:96] + e, st[95:64] + f, st[63:32] + g, st[31:0] + h};
  endfunction

  function automatic logic [255:0] dbl(input logic [255:0] m, input logic [95:0] tl,
                                       input logic [31:0] n);
    logic [255:0] h1, h2, r;
    h1 = compress(m, {tl, n[7:0], n[15:8], n[23:16], n[31:24], 32'h80000000, 320'b0, 32'd640});
    h2 = compress(SHA_IV, {h1, 32'h80000000, 192'b0, 32'd256});
    for (int i = 0; i < 32; i++) r[8*i +: 8] = h2[255-8*i -: 8];
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  // search over span nonces; expectation from the bench model
  task automatic search(input logic [255:0] m, input logic [95:0] tl, input logic [31:0] s,
                        input logic [255:0] t, input int span, input bit inject, input string req);
    bit          e_found = 0;
    logic [31:0] e_nonce = s;
    logic [255:0] e_hash = '0;
    int          tested = 0;
    int          n = 0;
    for (int i = 0; i < span; i++) begin
      e_nonce = s + 32'(i);
      e_hash  = dbl(m, tl, e_nonce);
      tested  = i + 1;
      if (e_hash <= t) begin e_found = 1; break; end
      if (e_nonce == 32'hFFFFFFFF) break;
    end
    @(negedge clk);
    mid = m; tail = tl; nstart = s; tgt = t; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R7 busy during search
    chk(busy && !found && !exh, "R7", "busy after start", {253'b0, busy, found, exh}, 256'b100);
    while (!found && !exh && n < 20000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (inject && n == 10) begin
        start = 1'b1; nstart = s + 32'd100; tgt = '1;
      end else start = 1'b0;
    end
    start = 1'b0;
    // R4 R5 R6: outcome, nonce and reversed digest
    chk(found == e_found, req, "found", 256'(found), 256'(e_found));
    chk(exh == !e_found, "R6", "exhausted", 256'(exh), 256'(!e_found));
    chk(nonce == e_nonce, "R5", "nonce", 256'(nonce), 256'(e_nonce));
    chk(hash == e_hash, "R4", "hash", hash, e_hash);
    // R8 latency
    chk(n == 132 * tested, "R8", "cycles", 256'(n), 256'(132 * tested));
    repeat (40) @(negedge clk);
    // R7 result held
    chk(found == e_found && exh == !e_found && nonce == e_nonce && hash == e_hash && !busy,
        "R7", "hold", {nonce, 222'b0, busy, found, exh}, {e_nonce, 222'b0, 1'b0, e_found, !e_found});
  endtask

  initial begin
    logic [255:0] m, hs [6], lo;
    logic [95:0]  tl;
    logic [31:0]  s;
    int           k;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !found && !exh, "R1", "flags", {253'b0, busy, found, exh}, '0);
    chk(nonce == 0 && hash == 0, "R1", "nonce/hash", 256'(nonce), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !found && !exh, "R1", "flags after release", {253'b0, busy, found, exh}, '0);

    // random headers, target taken from a digest in the window (R2 R3 R4 R5)
    for (int r = 0; r < 4; r++) begin
      m = rnd256(); tl = {$urandom, $urandom, $urandom}; s = $urandom;
      if (s > 32'hFFFFFF00) s = 32'h1000;
      k = int'($urandom % 6);
      for (int i = 0; i < 6; i++) hs[i] = dbl(m, tl, s + 32'(i));
      search(m, tl, s, hs[k], 6, (r == 1), (r % 2 == 0) ? "R2" : "R3");
    end

    // R4 all-ones target hits first nonce
    m = rnd256(); tl = {$urandom, $urandom, $urandom};
    search(m, tl, 32'h0, '1, 2, 1'b0, "R4");

    // R6 exhaustion across the top, target just below both digests
    m = rnd256(); tl = {$urandom, $urandom, $urandom};
    hs[0] = dbl(m, tl, 32'hFFFFFFFE);
    hs[1] = dbl(m, tl, 32'hFFFFFFFF);
    lo = (hs[0] < hs[1]) ? hs[0] : hs[1];
    search(m, tl, 32'hFFFFFFFE, lo - 1, 2, 1'b0, "R6");

    // R6 boundary: hit exactly on the last nonce is found, not exhausted
    search(m, tl, 32'hFFFFFFFF, hs[1], 1, 1'b0, "R6");

    finish_run();
  end
endmodule